// File: doc/BRIEF.md
# Flash Line Prefetch Buffer Controller

This block sits between a system read bus and a slow non-volatile array. It keeps two 128-bit line buffers. A read whose line is already buffered completes in the same cycle it is presented. A read that misses every buffer is captured in a register. The array line fetch is then issued on the next clock, and the read completes after a fixed three-cycle minimum plus a programmable number of extra wait states.

After a read completes, the controller can fetch the next sequential line from the array in the background. Each triggering read is tested against four conditions: a global enable, a per-master permission mask, and separate enables for instruction fetches and data reads. If a demand miss arrives while a background fetch is running, that fetch finishes before the miss is serviced. If the demand is for the line already being fetched, the read completes from the buffer as soon as the line lands. Buffers are refilled in least-recently-used order. A configuration write or an invalidate pulse empties all of them.

The array is not part of the block. It answers each one-cycle line request with a completion pulse that carries the whole line.

Top module: `flash_pfbuf`

## Requirements
- R1: A read whose line is held in a valid buffer has `req_ready` high in the same cycle it is presented, when no demand miss is in progress.
- R2: A read that misses all buffers while the controller is idle raises `ary_req` in the next cycle, with `ary_addr` equal to the request's byte address bits [23:4].
- R3: A missing read presented to an idle controller completes exactly 3 + `cfg_wait` cycles after its first cycle, when the array answers one cycle after `ary_req`.
- R4: When a read completes with prefetch qualified, the line following it (line address + 1) is requested from the array, unless it is already buffered, and a later read of that line hits.
- R5: With `cfg_pf_en` low, completed reads issue no array request and the following line still misses.
- R6: A read from master m triggers a prefetch only if bit m of `cfg_mst_mask` is set.
- R7: A read with `req_instr` high triggers a prefetch only if `cfg_pf_instr` is set. A read with `req_instr` low triggers one only if `cfg_pf_data` is set.
- R8: A demand miss to a different line that arrives while a prefetch is in flight waits for the prefetch to return, and its own array request follows the prefetch request.
- R9: A demand read of the line that a prefetch is currently fetching issues no new array request and completes in the cycle after the line returns.
- R10: A one-cycle pulse on `inv_all` or `cfg_write` invalidates every buffer from the next cycle, so the next read of a previously buffered line misses.
- R11: The returned word is `ary_line[32*w +: 32]` with w = `req_addr[3:2]` of the request.
- R12: A refill replaces the least recently used buffer, where a hit or a fill counts as a use.
- R13: During and right after reset, `req_ready` and `ary_req` are low and no buffer is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request, held until `req_ready` |
| req_addr | input | 24 | Byte address of the read |
| req_master | input | 2 | Requesting bus master number |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| req_ready | output | 1 | Read completes this cycle |
| rd_data | output | 32 | Read word, valid with `req_ready` |
| ary_req | output | 1 | One-cycle line request to the array |
| ary_addr | output | 20 | Line address of the array request |
| ary_done | input | 1 | Array line returned this cycle |
| ary_line | input | 128 | Returned line, valid with `ary_done` |
| cfg_pf_en | input | 1 | Prefetch enable |
| cfg_mst_mask | input | 4 | Masters allowed to trigger prefetch |
| cfg_pf_instr | input | 1 | Instruction fetches may trigger prefetch |
| cfg_pf_data | input | 1 | Data reads may trigger prefetch |
| cfg_wait | input | 4 | Extra wait states on a miss |
| cfg_write | input | 1 | Configuration write strobe, invalidates buffers |
| inv_all | input | 1 | Invalidate all buffers |

## Verification
Each result has a fixed cycle in which it is due. A hit is due in the request's own cycle. The array request for a miss is due one cycle later. The miss completion is due 3 + `cfg_wait` cycles after the first cycle. A prefetch request is due two cycles after the triggering completion. A demand that lands on an in-flight prefetch is due two cycles after it is raised, and one that waits behind a prefetch of another line is due 5 + `cfg_wait` cycles after it is raised. The bench drives inputs on the falling edge and samples `req_ready` and `rd_data` one nanosecond before each rising edge. It logs each array request at the rising edge that ends its cycle, so waits and array-request cycle numbers are compared as exact counts.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  // Controller phases: demand fetch issue/wait, prefetch issue/wait
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_D_ISS  = 3'd1,
    S_D_WAIT = 3'd2,
    S_P_ISS  = 3'd3,
    S_P_WAIT = 3'd4
  } fpb_state_e;

  localparam int unsigned FPB_LINE_BITS = 128;
  localparam int unsigned FPB_WORD_BITS = 32;
  localparam int unsigned FPB_NBUF      = 2;
  localparam int unsigned FPB_MIN_WAIT  = 3;
endpackage

// File: rtl/fpb_pf_gate.sv
module fpb_pf_gate #(
  parameter int NM = 4,
  parameter int MW = 2
) (
  input  logic          en_i,
  input  logic [NM-1:0] mask_i,
  input  logic          allow_instr_i,
  input  logic          allow_data_i,
  input  logic [MW-1:0] master_i,
  input  logic          instr_i,
  output logic          ok_o
);
  logic mst_ok;
  logic kind_ok;

  always_comb begin
    mst_ok  = mask_i[master_i];
    kind_ok = instr_i ? allow_instr_i : allow_data_i;
    ok_o    = en_i & mst_ok & kind_ok;
  end
endmodule

// File: rtl/fpb_linebuf.sv
module fpb_linebuf #(
  parameter int LW   = 20,
  parameter int LINE = 128,
  parameter int WORD = 32,
  parameter int NBUF = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic [LW-1:0]                 look_line_i,
  output logic                          look_hit_o,
  output logic [$clog2(NBUF)-1:0]       look_idx_o,
  input  logic [LW-1:0]                 probe_line_i,
  output logic                          probe_hit_o,
  input  logic                          touch_i,
  input  logic [$clog2(NBUF)-1:0]       touch_idx_i,
  input  logic                          fill_i,
  input  logic [$clog2(NBUF)-1:0]       fill_idx_i,
  input  logic [LW-1:0]                 fill_line_i,
  input  logic [LINE-1:0]               fill_data_i,
  input  logic [$clog2(NBUF)-1:0]       rd_idx_i,
  input  logic [$clog2(LINE/WORD)-1:0]  rd_sel_i,
  output logic [WORD-1:0]               rd_word_o,
  output logic [$clog2(NBUF)-1:0]       victim_o
);
  localparam int IW = $clog2(NBUF);

  logic [LINE-1:0] dat_all [NBUF];
  logic [LW-1:0]   tag_all [NBUF];
  logic [NBUF-1:0] vld_q, vld_d;
  logic [IW-1:0]   lru_q, lru_d;
  logic [NBUF-1:0] look_m, probe_m;

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic [LINE-1:0] dat_q;
    logic [LW-1:0]   tag_q;
    logic            wr_en;

    assign wr_en = fill_i && (fill_idx_i == IW'(b));

    always_ff @(posedge clk) begin
      if (wr_en) begin
        dat_q <= fill_data_i;
        tag_q <= fill_line_i;
      end
    end

    assign dat_all[b] = dat_q;
    assign tag_all[b] = tag_q;
    assign look_m[b]  = vld_q[b] && (tag_q == look_line_i);
    assign probe_m[b] = vld_q[b] && (tag_q == probe_line_i);
  end

  always_comb begin
    look_idx_o = '0;
    for (int b = 0; b < NBUF; b++) begin
      if (look_m[b]) look_idx_o = IW'(b);
    end
    look_hit_o  = |look_m;
    probe_hit_o = |probe_m;
    rd_word_o   = dat_all[rd_idx_i][rd_sel_i*WORD +: WORD];
    victim_o    = lru_q;
  end

  // next state: valid bits and replacement pointer (two-way: point at the other)
  always_comb begin
    vld_d = vld_q;
    lru_d = lru_q;
    if (fill_i) begin
      vld_d[fill_idx_i] = 1'b1;
      lru_d = ~fill_idx_i;
    end else if (touch_i) begin
      lru_d = ~touch_idx_i;
    end
    if (clr_i) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      lru_q <= '0;
    end else begin
      vld_q <= vld_d;
      lru_q <= lru_d;
    end
  end

  // R10
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (vld_q == '0));
  // R12
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && !clr_i) |=> vld_q[$past(fill_idx_i)]);
  // R12
  lru_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_i |=> (lru_q != $past(fill_idx_i)));
endmodule

// File: rtl/flash_pfbuf.sv
module flash_pfbuf
  import fpb_pkg::*;
#(
  parameter int AW = 24,
  parameter int NM = 4,
  parameter int MW = 2,
  parameter int WW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [AW-1:0]            req_addr,
  input  logic [MW-1:0]            req_master,
  input  logic                     req_instr,
  output logic                     req_ready,
  output logic [FPB_WORD_BITS-1:0] rd_data,
  output logic                     ary_req,
  output logic [AW-5:0]            ary_addr,
  input  logic                     ary_done,
  input  logic [FPB_LINE_BITS-1:0] ary_line,
  input  logic                     cfg_pf_en,
  input  logic [NM-1:0]            cfg_mst_mask,
  input  logic                     cfg_pf_instr,
  input  logic                     cfg_pf_data,
  input  logic [WW-1:0]            cfg_wait,
  input  logic                     cfg_write,
  input  logic                     inv_all
);
  localparam int LW = AW - 4;
  localparam int IW = $clog2(FPB_NBUF);
  localparam int SW = $clog2(FPB_LINE_BITS / FPB_WORD_BITS);
  localparam int CW = WW + 1;

  fpb_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] vic_q, vic_d;
  logic          got_q, got_d;
  logic [LW-1:0] dl_q, dl_d;
  logic [LW-1:0] pfl_q, pfl_d;
  logic          pend_q, pend_d;
  logic [LW-1:0] pendl_q, pendl_d;

  logic [LW-1:0] req_line;
  logic [SW-1:0] req_sel;
  logic          look_hit, probe_hit, pf_ok;
  logic [IW-1:0] look_idx, victim, rd_idx;
  logic          serve_hit, dw_done, trig, fill_en, clr;
  logic          unused_lsb;

  assign req_line   = req_addr[AW-1:4];
  assign req_sel    = req_addr[3:2];
  assign unused_lsb = ^req_addr[1:0];
  assign clr        = cfg_write | inv_all;

  fpb_pf_gate #(.NM(NM), .MW(MW)) u_gate (
    .en_i(cfg_pf_en), .mask_i(cfg_mst_mask), .allow_instr_i(cfg_pf_instr),
    .allow_data_i(cfg_pf_data), .master_i(req_master), .instr_i(req_instr),
    .ok_o(pf_ok)
  );

  fpb_linebuf #(.LW(LW), .LINE(FPB_LINE_BITS), .WORD(FPB_WORD_BITS), .NBUF(FPB_NBUF)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr_i(clr),
    .look_line_i(req_line), .look_hit_o(look_hit), .look_idx_o(look_idx),
    .probe_line_i(pendl_q), .probe_hit_o(probe_hit),
    .touch_i(serve_hit), .touch_idx_i(look_idx),
    .fill_i(fill_en), .fill_idx_i(vic_q),
    .fill_line_i((state_q == S_D_WAIT) ? dl_q : pfl_q), .fill_data_i(ary_line),
    .rd_idx_i(rd_idx), .rd_sel_i(req_sel), .rd_word_o(rd_data),
    .victim_o(victim)
  );

  always_comb begin
    serve_hit = req_valid && look_hit &&
                (state_q != S_D_ISS) && (state_q != S_D_WAIT);
    dw_done   = (state_q == S_D_WAIT) && got_q && (cnt_q == '0);
    req_ready = serve_hit | dw_done;
    rd_idx    = dw_done ? vic_q : look_idx;
    trig      = req_ready && pf_ok;
    fill_en   = ary_done && ((state_q == S_D_WAIT) || (state_q == S_P_WAIT));
    ary_req   = (state_q == S_D_ISS) || (state_q == S_P_ISS);
    ary_addr  = (state_q == S_D_ISS) ? dl_q : pfl_q;
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    vic_d   = vic_q;
    got_d   = got_q;
    dl_d    = dl_q;
    pfl_d   = pfl_q;
    pend_d  = pend_q;
    pendl_d = pendl_q;
    if (((state_q == S_D_ISS) || (state_q == S_D_WAIT)) && (cnt_q != '0))
      cnt_d = cnt_q - CW'(1);
    unique case (state_q)
      S_IDLE: begin
        if (req_valid && !look_hit) begin
          state_d = S_D_ISS;
          dl_d    = req_line;
          cnt_d   = CW'(cfg_wait) + CW'(FPB_MIN_WAIT - 1);
          vic_d   = victim;
          got_d   = 1'b0;
        end else if (pend_q) begin
          pend_d = 1'b0;
          if (!probe_hit) begin
            state_d = S_P_ISS;
            pfl_d   = pendl_q;
            vic_d   = victim;
          end
        end
      end
      S_D_ISS:  state_d = S_D_WAIT;
      S_D_WAIT: begin
        if (ary_done) got_d = 1'b1;
        if (dw_done)  state_d = S_IDLE;
      end
      S_P_ISS:  state_d = S_P_WAIT;
      S_P_WAIT: if (ary_done) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
    if (trig) begin
      pend_d  = 1'b1;
      pendl_d = req_line + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      got_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      got_q   <= got_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    vic_q   <= vic_d;
    dl_q    <= dl_d;
    pfl_q   <= pfl_d;
    pendl_q <= pendl_d;
  end

  // R2
  miss_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && req_valid && !look_hit)
      |=> (ary_req && ary_addr == $past(req_line)));
  // R3
  no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_D_ISS) |=> !req_ready);
  // R8
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ary_req |=> !ary_req);
  // R9
  pf_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_P_WAIT && ary_done) |=> (state_q == S_IDLE));
endmodule

// File: tb/flash_pfbuf_bench.sv
module flash_pfbuf_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_instr, req_ready;
  logic [23:0]  req_addr;
  logic [1:0]   req_master;
  logic [31:0]  rd_data;
  logic         ary_req, ary_done;
  logic [19:0]  ary_addr;
  logic [127:0] ary_line;
  logic         cfg_pf_en, cfg_pf_instr, cfg_pf_data, cfg_write, inv_all;
  logic [3:0]   cfg_mst_mask, cfg_wait;

  int tests = 0;
  int fails = 0;
  int ncyc = 0;
  int n_ary = 0;
  int last_cyc = 0;
  logic [19:0] last_ary = '0;
  logic [19:0] prev_ary = '0;

  always #5 clk = ~clk;

  flash_pfbuf u_flash_pfbuf (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_master(req_master), .req_instr(req_instr), .req_ready(req_ready),
    .rd_data(rd_data), .ary_req(ary_req), .ary_addr(ary_addr),
    .ary_done(ary_done), .ary_line(ary_line), .cfg_pf_en(cfg_pf_en),
    .cfg_mst_mask(cfg_mst_mask), .cfg_pf_instr(cfg_pf_instr),
    .cfg_pf_data(cfg_pf_data), .cfg_wait(cfg_wait), .cfg_write(cfg_write),
    .inv_all(inv_all)
  );

  function automatic logic [31:0] wval(logic [19:0] ln, logic [1:0] w);
    return ({10'd0, ln, w} * 32'h9E37_79B1) + 32'h0000_1234;
  endfunction

  function automatic logic [31:0] exp_word(logic [23:0] a);
    return wval(a[23:4], a[3:2]);
  endfunction

  // array model: answers one cycle after each request
  always @(posedge clk) begin
    if (!rst_n) ary_done <= 1'b0;
    else ary_done <= ary_req;
    for (int w = 0; w < 4; w++) ary_line[w*32 +: 32] <= wval(ary_addr, 2'(w));
  end

  // request log: cycle index ncyc before the edge ending the cycle
  always @(posedge clk) begin
    if (rst_n && ary_req) begin
      n_ary++;
      prev_ary = last_ary;
      last_ary = ary_addr;
      last_cyc = ncyc;
    end
    ncyc++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [23:0] a, input logic [1:0] m, input bit ins,
                    output int lat, output logic [31:0] d);
    bit done = 0;
    req_addr = a; req_master = m; req_instr = ins; req_valid = 1'b1;
    lat = 0; d = '0;
    while (!done) begin
      #4;
      if (req_ready) begin d = rd_data; done = 1; end
      else lat++;
      @(negedge clk);
      if (!done && lat > 200) begin
        check(0, "timeout", lat, 0);
        done = 1;
      end
    end
    req_valid = 1'b0;
  endtask

  task automatic set_cfg(input bit en, input logic [3:0] mask, input bit pi,
                         input bit pd, input logic [3:0] w);
    cfg_pf_en = en; cfg_mst_mask = mask; cfg_pf_instr = pi; cfg_pf_data = pd;
    cfg_wait = w; cfg_write = 1'b1;
    @(negedge clk);
    cfg_write = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat, s, n0;
    logic [31:0] d;
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_master = '0; req_instr = 1'b0;
    cfg_pf_en = 1'b0; cfg_mst_mask = 4'hF; cfg_pf_instr = 1'b1; cfg_pf_data = 1'b1;
    cfg_wait = 4'd0; cfg_write = 1'b0; inv_all = 1'b0;
    idle(3);
    check(!req_ready && !ary_req, "R13 idle outputs in reset", {req_ready, ary_req}, 0);
    rst_n = 1'b1;
    idle(1);

    // R13 / R2 / R3: first read after reset misses
    s = ncyc;
    rd(24'h000100, 2'd0, 1'b0, lat, d);
    check(lat == 3, "R13 R3 miss latency W=0", lat, 3);
    check(last_cyc == s + 1 && last_ary == 20'h00010, "R2 forward next cycle", last_cyc - s, 1);
    check(d == exp_word(24'h000100), "R11 word0", d, exp_word(24'h000100));
    // R1 / R11: other words of the buffered line
    for (int w = 1; w < 4; w++) begin
      rd(24'h000100 + 24'(w * 4), 2'd0, 1'b0, lat, d);
      check(lat == 0, "R1 hit zero wait", lat, 0);
      check(d == exp_word(24'h000100 + 24'(w * 4)), "R11 word select", d,
            exp_word(24'h000100 + 24'(w * 4)));
    end
    // R5: prefetch disabled
    n0 = n_ary; idle(6);
    check(n_ary == n0, "R5 no array request", n_ary - n0, 0);
    rd(24'h000110, 2'd0, 1'b0, lat, d);
    check(lat == 3, "R5 next line misses", lat, 3);

    // R3 with extra wait states; R10 invalidate
    set_cfg(0, 4'hF, 1, 1, 4'd5);
    rd(24'h000200, 2'd1, 1'b0, lat, d);
    check(lat == 8, "R3 miss latency W=5", lat, 8);
    rd(24'h000204, 2'd1, 1'b0, lat, d);
    check(lat == 0, "R1 hit after W=5 fill", lat, 0);
    inv_all = 1'b1; idle(1); inv_all = 1'b0;
    rd(24'h000200, 2'd1, 1'b0, lat, d);
    check(lat == 8, "R10 inv_all forces miss", lat, 8);
    set_cfg(0, 4'hF, 1, 1, 4'd5);
    rd(24'h000200, 2'd1, 1'b0, lat, d);
    check(lat == 8, "R10 cfg_write forces miss", lat, 8);

    // R4: sequential prefetch
    set_cfg(1, 4'hF, 1, 1, 4'd0);
    rd(24'h000300, 2'd0, 1'b1, lat, d);
    idle(6);
    check(last_ary == 20'h00031, "R4 next line requested", last_ary, 20'h00031);
    rd(24'h000318, 2'd0, 1'b1, lat, d);
    check(lat == 0 && d == exp_word(24'h000318), "R4 prefetched line hits", lat, 0);
    idle(6);

    // R6: master mask
    set_cfg(1, 4'b0001, 1, 1, 4'd0);
    rd(24'h000400, 2'd2, 1'b0, lat, d);
    n0 = n_ary; idle(6);
    check(n_ary == n0, "R6 masked master no prefetch", n_ary - n0, 0);
    rd(24'h000410, 2'd2, 1'b0, lat, d);
    check(lat == 3, "R6 masked master next line misses", lat, 3);
    rd(24'h000500, 2'd0, 1'b0, lat, d);
    idle(6);
    check(last_ary == 20'h00051, "R6 allowed master prefetches", last_ary, 20'h00051);

    // R7: instruction/data trigger enables
    set_cfg(1, 4'hF, 1, 0, 4'd0);
    rd(24'h000600, 2'd3, 1'b0, lat, d);
    n0 = n_ary; idle(6);
    check(n_ary == n0, "R7 data read blocked", n_ary - n0, 0);
    rd(24'h000700, 2'd3, 1'b1, lat, d);
    idle(6);
    check(last_ary == 20'h00071, "R7 instr fetch prefetches", last_ary, 20'h00071);
    set_cfg(1, 4'hF, 0, 1, 4'd0);
    rd(24'h000800, 2'd3, 1'b1, lat, d);
    n0 = n_ary; idle(6);
    check(n_ary == n0, "R7 instr fetch blocked", n_ary - n0, 0);
    rd(24'h000900, 2'd3, 1'b0, lat, d);
    idle(6);
    check(last_ary == 20'h00091, "R7 data read prefetches", last_ary, 20'h00091);

    // R9: demand to in-flight line
    set_cfg(1, 4'hF, 1, 1, 4'd0);
    rd(24'h000A00, 2'd0, 1'b0, lat, d);
    idle(1);
    n0 = n_ary;
    rd(24'h000A14, 2'd0, 1'b0, lat, d);
    check(lat == 2, "R9 completes after line arrives", lat, 2);
    check(n_ary == n0 + 1, "R9 no extra array request", n_ary - n0, 1);
    check(d == exp_word(24'h000A14), "R9 data", d, exp_word(24'h000A14));
    idle(6);

    // R8: demand to other line waits behind prefetch
    rd(24'h000B00, 2'd0, 1'b0, lat, d);
    idle(1);
    rd(24'h000C08, 2'd0, 1'b0, lat, d);
    check(lat == 5, "R8 waits for prefetch", lat, 5);
    check(prev_ary == 20'h000B1 && last_ary == 20'h000C0, "R8 request order", last_ary, 20'h000C0);
    check(d == exp_word(24'h000C08), "R8 data", d, exp_word(24'h000C08));
    idle(6);

    // R12: LRU replacement
    set_cfg(0, 4'hF, 1, 1, 4'd0);
    rd(24'h000D00, 2'd0, 1'b0, lat, d);
    rd(24'h000E00, 2'd0, 1'b0, lat, d);
    rd(24'h000D04, 2'd0, 1'b0, lat, d);
    check(lat == 0, "R12 touch hit", lat, 0);
    rd(24'h000F00, 2'd0, 1'b0, lat, d);
    rd(24'h000D08, 2'd0, 1'b0, lat, d);
    check(lat == 0, "R12 recently used line kept", lat, 0);
    rd(24'h000E00, 2'd0, 1'b0, lat, d);
    check(lat == 3, "R12 least recent line evicted", lat, 3);

    // random mix; R11 data and latency bound R3
    for (int i = 0; i < 300; i++) begin
      logic [23:0] a;
      if (i % 50 == 0)
        set_cfg(1'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 4'($urandom % 4));
      a = {15'd0, 5'($urandom % 32), 2'($urandom), 2'b00};
      rd(a, 2'($urandom), 1'($urandom), lat, d);
      check(d == exp_word(a), "R11 random data", d, exp_word(a));
      check(lat <= 5 + int'(cfg_wait), "R3 random latency bound", lat, 5 + int'(cfg_wait));
      idle($urandom % 3);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule